// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a small byte-wide status word that records which internal event asked for the most recent reset. Five internal sources feed it, each through a one-cycle request pulse. The sources are an illegal-opcode detector built into the block, a watchdog timeout, a clock-monitor fault, an illegal memory access and a low-voltage detector. The watchdog and clock-monitor requests share one flag. Every source that fires also raises a combined reset-request output, which a separate pulse generator uses.

The flags live in registers that only the power-on reset and the external reset pin clear. An internal reset therefore leaves the record in place, and later events add to it. Software reads the whole byte through a read strobe. The read clears every flag, unless a new event arrives in that same cycle, in which case the new event wins. The opcode check compares the decoded instruction byte with 0xFF. A debug-mode input masks this check.

The asynchronous active-low reset `rst_n` is the power-on reset. Its release is assumed to be synchronised to `clk` upstream.

Top module: `reset_cause_capture`

## Requirements
- R1: The read image places the trap flag at bit 7, the watchdog/clock-monitor flag at bit 4, the illegal-access flag at bit 1 and the low-voltage flag at bit 0. Bits 6, 5, 3 and 2 are always 0. `rd_data_o` loads this image at the clock edge where `rd_stb_i` is high, using the flag values held before that edge, and keeps its value otherwise.
- R2: A read (`rd_stb_i` high at an edge) clears every flag that is not being set in that same cycle.
- R3: `pin_rst_i` high at an edge clears all flags, and it overrides any set in that cycle. `rst_n` low clears the flags, `rd_data_o` and `rst_req_o` at once, without waiting for a clock edge.
- R4: When `op_valid_i` is high, `op_byte_i` equals 0xFF and `dbg_mode_i` is low, the trap flag is set at the next edge.
- R5: While `dbg_mode_i` is high, opcode 0xFF sets no flag and causes no reset request.
- R6: `wdt_expire_i`, `clkmon_fault_i`, or both together, set the single bit-4 flag.
- R7: A flag stays set through later source events and reset requests, until a read, a pin reset or a power-on reset clears it. The flags accumulate.
- R8: `rst_req_o` is high in the cycle after any internal source fires, including an ungated trap. Otherwise it is low.
- R9: If a flag is set in the same cycle as a read, the read returns the old image without the new flag, and the new flag remains set afterward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| pin_rst_i | input | 1 | External reset pin, synchronous clear of the flags, active high |
| op_valid_i | input | 1 | The instruction byte is being executed this cycle |
| op_byte_i | input | 8 | Decoded instruction byte |
| dbg_mode_i | input | 1 | Debug mode, masks opcode trap detection |
| wdt_expire_i | input | 1 | Watchdog timeout pulse |
| clkmon_fault_i | input | 1 | Clock-monitor fault pulse |
| bad_access_i | input | 1 | Illegal memory access pulse |
| low_volt_i | input | 1 | Low-voltage detector pulse |
| rd_stb_i | input | 1 | Whole-byte read strobe |
| rd_data_o | output | 8 | Captured read image |
| rst_req_o | output | 1 | Combined internal reset request |

## Verification
The bench targets a set and a read that arrive in the same cycle. A design that gives the read priority would lose the new cause, and one that loads the image after the set would report the new flag too early. It drives the watchdog and clock-monitor pulses together and one at a time, to catch a shared flag wired to only one source. It drives opcode 0xFF under debug mode, where a missing gate shows up as a stray trap flag and a stray request. It applies pin and power-on resets while events are pending, and checks that flags gathered over several internal requests survive until a read.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int IMG_W     = 8;

  // event index -> position in the read image
  typedef enum int {
    EV_LOWV = 0,
    EV_BADA = 1,
    EV_WDCM = 2,
    EV_TRAP = 3
  } ev_idx_e;

  localparam int FLAG_POS [NUM_FLAGS] = '{0, 1, 4, 7};

  function automatic logic [IMG_W-1:0] image_mask();
    logic [IMG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_FLAGS; i++) m[FLAG_POS[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rcc_trap_detect.sv
module rcc_trap_detect #(
  parameter int              OP_W    = 8,
  parameter logic [OP_W-1:0] TRAP_OP = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            dbg_i,
  output logic            hit_o
);
  logic match;

  always_comb begin
    match = valid_i && (op_i == TRAP_OP);
    hit_o = match && !dbg_i;
  end

  // R5: under debug mode the trap opcode never produces a hit
  p_dbg_masks_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == TRAP_OP) && dbg_i) |-> !hit_o);
  // R4: the trap opcode outside debug mode always produces a hit
  p_trap_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == TRAP_OP) && !dbg_i) |-> hit_o);
endmodule

// File: rtl/rcc_flag_cell.sv
module rcc_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic set_i,
  input  logic rd_i,
  output logic q_o
);
  logic q_q, q_d, q_en;

  // priority: pin clear, then set, then read clear
  always_comb begin
    q_en = clr_i | set_i | rd_i;
    q_d  = q_q;
    if (clr_i)      q_d = 1'b0;
    else if (set_i) q_d = 1'b1;
    else if (rd_i)  q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;

  p_pin_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);
  p_set_wins_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_o);
  p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !set_i && !clr_i) |=> !q_o);
  p_flag_persists_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !clr_i && q_o) |=> q_o);
endmodule

// File: rtl/reset_cause_capture.sv
module reset_cause_capture
  import rcc_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_rst_i,
  input  logic             op_valid_i,
  input  logic [OP_W-1:0]  op_byte_i,
  input  logic             dbg_mode_i,
  input  logic             wdt_expire_i,
  input  logic             clkmon_fault_i,
  input  logic             bad_access_i,
  input  logic             low_volt_i,
  input  logic             rd_stb_i,
  output logic [IMG_W-1:0] rd_data_o,
  output logic             rst_req_o
);
  localparam logic [IMG_W-1:0] MASK = image_mask();

  logic                 trap_hit;
  logic [NUM_FLAGS-1:0] ev;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [IMG_W-1:0]     img;
  logic [IMG_W-1:0]     rd_q, rd_d;
  logic                 rd_en;
  logic                 req_q, req_d;

  rcc_trap_detect #(.OP_W(OP_W)) u_trap (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (op_valid_i),
    .op_i    (op_byte_i),
    .dbg_i   (dbg_mode_i),
    .hit_o   (trap_hit)
  );

  always_comb begin
    ev          = '0;
    ev[EV_LOWV] = low_volt_i;
    ev[EV_BADA] = bad_access_i;
    ev[EV_WDCM] = wdt_expire_i | clkmon_fault_i;
    ev[EV_TRAP] = trap_hit;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    rcc_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (pin_rst_i),
      .set_i (ev[g]),
      .rd_i  (rd_stb_i),
      .q_o   (flag_q[g])
    );
  end

  always_comb begin
    img = '0;
    for (int i = 0; i < NUM_FLAGS; i++) img[FLAG_POS[i]] = flag_q[i];
  end

  // next-state
  always_comb begin
    rd_en = rd_stb_i;
    rd_d  = img;
    req_d = |ev;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign rd_data_o = rd_q;
  assign rst_req_o = req_q;

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & ~MASK) == '0);
  p_read_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rd_data_o));
  p_shared_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((wdt_expire_i || clkmon_fault_i) && !pin_rst_i) |=> flag_q[EV_WDCM]);
  p_req_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_expire_i || clkmon_fault_i || bad_access_i || low_volt_i) |=> rst_req_o);
  p_no_req_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_expire_i && !clkmon_fault_i && !bad_access_i && !low_volt_i
     && (dbg_mode_i || !op_valid_i)) |=> !rst_req_o);
endmodule

// File: tb/tb_reset_cause_capture.sv
module tb_reset_cause_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_rst_i = 1'b0, op_valid_i = 1'b0, dbg_mode_i = 1'b0;
  logic [7:0] op_byte_i = '0;
  logic       wdt_expire_i = 1'b0, clkmon_fault_i = 1'b0;
  logic       bad_access_i = 1'b0, low_volt_i = 1'b0, rd_stb_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rst_req_o;

  int checks = 0, errors = 0;
  logic [3:0] m_flags = '0;   // {trap, wdcm, bada, lowv}
  logic [7:0] m_rd = '0;
  logic       m_req = 1'b0;

  always #5 clk = ~clk;

  reset_cause_capture dut (.*);

  function automatic logic [7:0] img(logic [3:0] f);
    return {f[3], 2'b00, f[2], 2'b00, f[1], f[0]};
  endfunction

  task automatic check(string tag);
    checks++;
    if (rd_data_o !== m_rd) begin
      errors++;
      $display("FAIL %s rd_data actual %h expected %h", tag, rd_data_o, m_rd);
    end
    checks++;
    if (rst_req_o !== m_req) begin
      errors++;
      $display("FAIL %s rst_req actual %b expected %b", tag, rst_req_o, m_req);
    end
  endtask

  // called just after a negedge: apply inputs, update model, check at next negedge
  task automatic drive(input logic ov, input logic [7:0] op, input logic dbg,
                       input logic wd, input logic cm, input logic ba,
                       input logic lv, input logic rd, input logic pin,
                       input string tag);
    logic [3:0] ev;
    op_valid_i = ov; op_byte_i = op; dbg_mode_i = dbg; wdt_expire_i = wd;
    clkmon_fault_i = cm; bad_access_i = ba; low_volt_i = lv; rd_stb_i = rd;
    pin_rst_i = pin;
    ev = {ov && op == 8'hFF && !dbg, wd | cm, ba, lv};
    m_req = |ev;
    if (rd) m_rd = img(m_flags);
    for (int i = 0; i < 4; i++)
      m_flags[i] = pin ? 1'b0 : ev[i] ? 1'b1 : rd ? 1'b0 : m_flags[i];
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(string tag);
    drive(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(string tag);
    drive(0, 8'h00, 0, 0, 0, 0, 0, 1, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R3 power-on state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 after release");

    // R4 trap alone, then read
    drive(1, 8'hFF, 0, 0, 0, 0, 0, 0, 0, "R4 trap request R8");
    rd("R4 read trap image");
    idle("R2 idle");
    rd("R2 read after clear");
    // R6 shared flag: each source and both together
    drive(0, 8'h00, 0, 1, 0, 0, 0, 0, 0, "R6 watchdog");
    rd("R6 watchdog image R1");
    drive(0, 8'h00, 0, 0, 1, 0, 0, 0, 0, "R6 clock monitor");
    rd("R6 clock monitor image");
    drive(0, 8'h00, 0, 1, 1, 0, 0, 0, 0, "R6 both");
    rd("R6 both image");
    drive(0, 8'h00, 0, 0, 0, 1, 0, 0, 0, "R1 bad access");
    rd("R1 bad access image");
    drive(0, 8'h00, 0, 0, 0, 0, 1, 0, 0, "R1 low voltage");
    rd("R1 low voltage image");
    // R5 debug masks trap
    drive(1, 8'hFF, 1, 0, 0, 0, 0, 0, 0, "R5 debug trap no request");
    rd("R5 debug trap no flag");
    drive(1, 8'hFE, 0, 0, 0, 0, 0, 0, 0, "R4 non-trap opcode");
    rd("R4 non-trap opcode no flag");
    // R7 accumulation
    drive(0, 8'h00, 0, 0, 0, 0, 1, 0, 0, "R7 first cause");
    idle("R7 gap");
    drive(1, 8'hFF, 0, 0, 0, 0, 0, 0, 0, "R7 second cause");
    drive(0, 8'h00, 0, 0, 0, 1, 0, 0, 0, "R7 third cause");
    rd("R7 accumulated image");
    // R9 set with read same cycle
    drive(0, 8'h00, 0, 1, 0, 0, 0, 0, 0, "R9 prior");
    drive(0, 8'h00, 0, 0, 0, 1, 0, 1, 0, "R9 set during read");
    rd("R9 new flag kept");
    // R3 pin clears and overrides set
    drive(0, 8'h00, 0, 1, 0, 1, 1, 0, 0, "R3 preset");
    drive(1, 8'hFF, 0, 0, 0, 0, 0, 0, 1, "R3 pin with trap");
    rd("R3 pin cleared");
    // R3 power-on reset mid-run
    drive(1, 8'hFF, 0, 1, 0, 1, 1, 0, 0, "R3 before por");
    rst_n = 1'b0;
    #2;
    m_flags = '0; m_rd = '0; m_req = 1'b0;
    check("R3 por async clear");
    @(negedge clk);
    rst_n = 1'b1;
    rd("R3 flags after por");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic ov, dbg, wd, cm, ba, lv, r, pin;
      logic [7:0] op;
      ov  = ($urandom % 3) == 0;
      op  = (($urandom % 4) == 0) ? 8'hFF : 8'($urandom);
      dbg = ($urandom % 4) == 0;
      wd  = ($urandom % 12) == 0;
      cm  = ($urandom % 12) == 0;
      ba  = ($urandom % 12) == 0;
      lv  = ($urandom % 12) == 0;
      r   = ($urandom % 4) == 0;
      pin = ($urandom % 40) == 0;
      drive(ov, op, dbg, wd, cm, ba, lv, r, pin, "R1 random R2 R7 R8 R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule